// File: doc/BRIEF.md
# Serial Controller Interrupt Status Unit

This block keeps the raw interrupt status of a serial controller and turns it into one level-sensitive interrupt request. Three single-cycle event strobes each set a sticky raw bit: transfer complete, receive data ready and receive overrun. The controller's 32-bit control word is an input. Its per-source enable bits sit at positions that differ from the status bits. They are moved onto the status positions and ANDed with the raw bits to give the masked status. The interrupt request is high while any masked bit is set.

Software clears raw bits by writing ones to a dedicated clear register. The block sees a register-file write strobe, a word index and write data, and decodes only the index of the clear register. Writes to every other index, including the raw, masked and general status words, leave the raw bits unchanged. The raw and masked words are driven continuously so a register file can return them on a read.

Top module: `sirq_status_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the raw status reads zero, the masked status reads zero and the interrupt output is low.
- R2: An event strobe on bit k of `evt` sets raw bit k on the next clock edge. Bit 0 is transfer done, bit 1 is receive ready and bit 2 is receive overrun. The bit then stays set until it is cleared.
- R3: The enables are taken from the control word as follows: control bit 5 enables status bit 0, control bit 4 enables status bit 1 and control bit 6 enables status bit 2. The masked status equals the raw status ANDed with these remapped enables. All other control bits have no effect.
- R4: The interrupt output is high exactly when at least one masked status bit is set.
- R5: A write to word index 3 (the clear register) clears raw bit k for each k in 0..2 where write data bit k is 1. Raw bits whose data bit is 0 keep their value. The change is seen after the write's clock edge.
- R6: A write to any word index other than 3, including index 2 (general status), 8 (masked status) and 9 (raw status), leaves the raw status unchanged.
- R7: If an event strobe and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: The masked status and interrupt output follow the control word combinationally. Clearing an enable drops its masked bit and, if no other masked bit is set, the interrupt, without waiting for a clock edge.
- R9: Bits 31..3 of the raw and masked status outputs always read zero. Write data bits 31..3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 3 | Event strobes: bit 0 transfer done, bit 1 receive ready, bit 2 receive overrun |
| ctrl_word | input | 32 | Controller control word carrying the enables at bits 5, 4 and 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word index of the write |
| wr_data | input | 32 | Write data |
| raw_stat | output | 32 | Raw status word |
| mask_stat | output | 32 | Masked status word |
| irq | output | 1 | Level interrupt request |

## Verification
The case that is hardest to reach from the ports is an event strobe and a clear write landing on the same bit in the same cycle, under every possible prior raw state. The stimulus first forces the raw status to each of the eight patterns, using a clear-all write followed by an event burst. It then applies every combination of event vector and clear mask in a single cycle, so the set-over-clear rule is covered for each bit against each neighbour state. The combinational mask path is exercised by changing the control word between clock edges and sampling before the next edge. Upper control bits are filled with noise to show that they are ignored.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NUM_SRC  = 3;
    localparam int SRC_DONE = 0;
    localparam int SRC_RXRD = 1;
    localparam int SRC_OVF  = 2;

    // control-word position of the enable for each status bit
    function automatic int en_pos(input int src);
        case (src)
            SRC_DONE: en_pos = 5;
            SRC_RXRD: en_pos = 4;
            default:  en_pos = 6;
        endcase
    endfunction
endpackage

// File: rtl/sirq_en_remap.sv
module sirq_en_remap
    import sirq_pkg::*;
#(
    parameter int CTRL_W = 32
) (
    input  logic [CTRL_W-1:0]  ctrl_word,
    output logic [NUM_SRC-1:0] en
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_map
        assign en[k] = ctrl_word[en_pos(k)];
    end
endmodule

// File: rtl/sirq_raw_bit.sv
module sirq_raw_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sirq_mask_reduce.sv
module sirq_mask_reduce
    import sirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] masked,
    output logic               req
);
    always_comb begin
        masked = raw & en;
        req    = |masked;
    end
endmodule

// File: rtl/sirq_status_unit.sv
module sirq_status_unit
    import sirq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int CLR_IDX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] raw_stat,
    output logic [DATA_W-1:0] mask_stat,
    output logic              irq
);
    localparam int PAD_W = DATA_W - NUM_SRC;
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_IDX);

    logic               clr_hit;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] en_map;
    logic [NUM_SRC-1:0] masked;
    logic               unused_bits;

    assign clr_hit     = wr_en && (wr_addr == CLR_A);
    assign unused_bits = ^{wr_data[DATA_W-1:NUM_SRC], ctrl_word};

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_raw
        sirq_raw_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt[k]),
            .clr_i (clr_hit & wr_data[k]),
            .q_o   (raw_q[k])
        );
    end

    sirq_en_remap #(.CTRL_W(DATA_W)) u_remap (
        .ctrl_word (ctrl_word),
        .en        (en_map)
    );

    sirq_mask_reduce u_mask (
        .raw    (raw_q),
        .en     (en_map),
        .masked (masked),
        .req    (irq)
    );

    assign raw_stat  = {{PAD_W{1'b0}}, raw_q};
    assign mask_stat = {{PAD_W{1'b0}}, masked};
endmodule

// File: rtl/sirq_status_chk.sv
module sirq_status_chk
    import sirq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int CLR_IDX = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SRC-1:0] evt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] raw_stat,
    input logic [DATA_W-1:0] mask_stat,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_IDX);

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> raw_stat == '0);

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt != '0 |=> (raw_stat[NUM_SRC-1:0] & $past(evt)) == $past(evt));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CLR_A && evt == '0)
        |=> (raw_stat[NUM_SRC-1:0] & $past(wr_data[NUM_SRC-1:0])) == '0);

    // R6
    other_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CLR_A && evt == '0) |=> $stable(raw_stat));

    // R4
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (mask_stat != '0));

    // R3
    mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_stat & ~raw_stat) == '0);

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_stat[DATA_W-1:NUM_SRC] == '0 && mask_stat[DATA_W-1:NUM_SRC] == '0);
endmodule

bind sirq_status_unit sirq_status_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CLR_IDX (CLR_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .raw_stat  (raw_stat),
    .mask_stat (mask_stat),
    .irq       (irq)
);

// File: tb/sirq_status_unit_test.sv
module sirq_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt = '0;
    logic [31:0] ctrl_word = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] raw_stat;
    logic [31:0] mask_stat;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sirq_status_unit uut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .ctrl_word(ctrl_word),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // enable bits 0,1,2 placed at control bits 5,4,6
    function automatic logic [31:0] ctrl_of(input logic [2:0] en, input logic [31:0] noise);
        logic [31:0] c;
        c = noise & ~32'h0000_0070;
        c[5] = en[0];
        c[4] = en[1];
        c[6] = en[2];
        return c;
    endfunction

    task automatic step(input logic [2:0] e, input logic we, input logic [3:0] a, input logic [31:0] d);
        evt = e; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        #3;
        evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic load(input logic [2:0] p);
        step(3'b000, 1'b1, 4'd3, 32'hFFFF_FFFF);
        step(p, 1'b0, 4'd0, 32'h0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        ctrl_word = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #3;
        // R1: during reset
        chk(raw_stat == 0 && mask_stat == 0 && irq == 0, "R1 in reset", raw_stat, 0);
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk(raw_stat == 0 && mask_stat == 0 && irq == 0, "R1 after reset", raw_stat, 0);

        // R2, R5, R7, R9: every prior state, event vector and clear mask
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 8; c++) begin
                for (int e = 0; e < 8; e++) begin
                    logic [31:0] expv;
                    load(3'(p));
                    chk(raw_stat == 32'(p), "R2 load", raw_stat, 32'(p));
                    step(3'(e), 1'b1, 4'd3, 32'(c) | 32'hA5A5_A5A0);
                    expv = 32'((p & ~c) | e);
                    if ((e & c) != 0)
                        chk(raw_stat == expv, "R7 set beats clear", raw_stat, expv);
                    else if (e == 0)
                        chk(raw_stat == expv, "R5 write-one clear", raw_stat, expv);
                    else
                        chk(raw_stat == expv, "R2 set during clear", raw_stat, expv);
                end
            end
        end

        // R2: sticky across idle cycles
        load(3'b101);
        step(3'b000, 1'b0, 4'd0, 32'h0);
        step(3'b000, 1'b0, 4'd0, 32'h0);
        chk(raw_stat == 32'h5, "R2 sticky", raw_stat, 32'h5);

        // R3, R4, R9: every raw state against every enable set, two noise patterns
        for (int p = 0; p < 8; p++) begin
            load(3'(p));
            for (int en = 0; en < 8; en++) begin
                for (int n = 0; n < 2; n++) begin
                    logic [31:0] m;
                    ctrl_word = ctrl_of(3'(en), n == 0 ? 32'h0 : 32'hFFFF_FFFF);
                    #1;
                    m = 32'(p & en);
                    chk(mask_stat == m, "R3 masked status", mask_stat, m);
                    chk(irq == (m != 0), "R4 irq level", 32'(irq), 32'(m != 0));
                end
            end
        end

        // R8: dropping enables between edges
        ctrl_word = ctrl_of(3'b111, 32'h0);
        load(3'b011);
        @(negedge clk);
        ctrl_word = ctrl_of(3'b010, 32'h0);
        #1;
        chk(mask_stat == 32'h2 && irq == 1'b1, "R8 drop bit0 enable", mask_stat, 32'h2);
        ctrl_word = ctrl_of(3'b000, 32'h0);
        #1;
        chk(mask_stat == 32'h0 && irq == 1'b0, "R8 drop all enables", mask_stat, 32'h0);
        ctrl_word = ctrl_of(3'b111, 32'h0);
        @(posedge clk); #3;

        // R6: writes of all ones to every other index
        for (int a = 0; a < 16; a++) begin
            if (a != 3) begin
                logic [2:0] p;
                p = (a % 2 == 0) ? 3'b111 : 3'b101;
                load(p);
                step(3'b000, 1'b1, 4'(a), 32'hFFFF_FFFF);
                chk(raw_stat == 32'(p), "R6 ignored write", raw_stat, 32'(p));
            end
        end

        // R9: upper data bits alone clear nothing
        load(3'b111);
        step(3'b000, 1'b1, 4'd3, 32'hFFFF_FFF8);
        chk(raw_stat == 32'h7, "R9 upper data bits", raw_stat, 32'h7);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule